// File: doc/BRIEF.md
# Bus Master Access Guard

The block checks every bus access that any of four bus masters makes towards two groups of peripheral slots. One group has 17 slots, and each slot has its own 4-bit rights field. The other group has 14 slots, and one rights byte covers all of them. For each access the block takes the master number, the supervisor/user attribute the master presents, the access kind (read, write or instruction fetch) and the target slot. In the same cycle it raises either a grant or a one-cycle error.

A small programming port holds the rights. It also holds a privilege byte that marks which masters are trusted and which non-core masters may present a supervisor attribute. The port ignores every write issued by a master that is not trusted. Master 0, the processor core, is the only trusted master out of reset. Its attribute is always honoured. The other masters run as user level until they are enabled.

Top module: `bus_access_guard`

## Requirements
- R1: After reset the readback values are: privilege byte 8'h01; per-slot registers 0..7 8'hCC; per-slot register 8 8'h0C; grouped byte 8'hC0.
- R2: Programming addresses are: 0 = privilege byte, 1..9 = per-slot registers 0..8, 10 = grouped byte. A read from any other address returns 0. A write to any other address changes nothing.
- R3: A write on the programming port takes effect at the next clock edge, and only if the trust bit of the issuing master is set. A write from an untrusted master leaves all registers unchanged.
- R4: Privilege byte layout: bits 3:0 are the trust bits, bit n for master n. Bits 7:5 let masters 1..3 (bit 4+n) present supervisor level. Bit 4 always reads 0. Master 0's attribute is always honoured. A master 1..3 whose enable bit is clear is treated as user level whatever attribute it presents.
- R5: Per-slot slot s uses register s/2. Even slots use bits 3:0 and odd slots use bits 7:4. Bits 7:4 of register 8 always read 0.
- R6: Access kind codes: 0 = read, 1 = write, 2 = fetch, 3 = reserved and always denied. Per-slot field: bit 3 = supervisor read, bit 2 = supervisor write, bit 1 = user read, bit 0 = user write. A per-slot read or write is granted when its bit is set at the effective level.
- R7: A fetch to the per-slot space is denied. An access to a per-slot number of 17 or more is denied.
- R8: Grouped byte layout: bit 7 = supervisor read, bit 6 = supervisor write, bit 5 = supervisor fetch, bit 4 = user read, bit 3 = user write, bit 2 = user fetch. Bits 1:0 read 0. An access to a grouped slot of 14 or more is denied.
- R9: In the same cycle as a valid access, exactly one of grant and error is high, and the outputs are combinational. When no access is valid, both are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_master | input | 2 | Number of the issuing master |
| acc_super | input | 1 | Supervisor attribute presented by the master |
| acc_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 reserved |
| acc_grouped | input | 1 | 1 = target is in the grouped 14-slot space |
| acc_slot | input | 5 | Target slot number |
| acc_grant | output | 1 | Access permitted |
| acc_error | output | 1 | Access denied (one-cycle pulse) |
| cfg_we | input | 1 | Programming write strobe |
| cfg_master | input | 2 | Master issuing the programming write |
| cfg_addr | input | 4 | Programming address |
| cfg_wdata | input | 8 | Programming write data |
| cfg_rdata | output | 8 | Readback of the register at cfg_addr |

## Verification
On every cycle, the assertions check four things:
- grant and error are mutually exclusive and follow acc_valid;
- a write from an untrusted master leaves the whole register file untouched;
- a disabled non-core master never reaches supervisor level;
- per-slot fetches and out-of-range slots are never granted.

Only the bench's sweeps can show the rest. That covers the exact decoding of every nibble and grouped bit for every master, level, kind and slot. It also covers the reset readback, the masking of pad bits and the handover of trust between masters.

// File: rtl/guard_pkg.sv
package guard_pkg;

    typedef enum logic [1:0] {
        KIND_READ  = 2'd0,
        KIND_WRITE = 2'd1,
        KIND_FETCH = 2'd2,
        KIND_RSVD  = 2'd3
    } acc_kind_e;

    localparam logic [7:0] SLOT_RESET  = 8'hCC;
    localparam logic [7:0] GROUP_RESET = 8'hC0;
    localparam logic [7:0] GROUP_MASK  = 8'hFC;

endpackage

// File: rtl/guard_regs.sv
module guard_regs
    import guard_pkg::*;
#(
    parameter int NUM_MASTERS = 4,
    parameter int NUM_PSLOTS  = 17,
    parameter int AW          = 4,
    localparam int MW         = $clog2(NUM_MASTERS),
    localparam int NUM_PREGS  = (NUM_PSLOTS + 1) / 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [MW-1:0]               cfg_master,
    input  logic [AW-1:0]               cfg_addr,
    input  logic [7:0]                  cfg_wdata,
    output logic [7:0]                  cfg_rdata,
    output logic [NUM_MASTERS-1:1]      attr_en_q,
    output logic [NUM_PREGS-1:0][7:0]   preg_q,
    output logic [7:0]                  grp_q
);

    localparam int ADDR_GRP = NUM_PREGS + 1;

    function automatic logic [7:0] priv_mask_f();
        logic [7:0] m;
        m = '0;
        for (int n = 0; n < NUM_MASTERS; n++) begin
            m[n] = 1'b1;
            if (n > 0) m[4 + n] = 1'b1;
        end
        return m;
    endfunction

    localparam logic [7:0] PRIV_MASK = priv_mask_f();
    localparam logic [7:0] PRIV_RST  = 8'h01;
    localparam logic [7:0] LAST_MASK = (NUM_PSLOTS % 2 == 1) ? 8'h0F : 8'hFF;

    logic [7:0] priv_q;
    logic       wr_ok;

    assign wr_ok = cfg_we && priv_q[cfg_master];

    // Privilege byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            priv_q <= PRIV_RST;
        end else if (wr_ok && cfg_addr == AW'(0)) begin
            priv_q <= cfg_wdata & PRIV_MASK;
        end
    end

    // Per-slot registers, one process each
    for (genvar i = 0; i < NUM_PREGS; i++) begin : g_preg
        localparam logic [7:0] MASK = (i == NUM_PREGS - 1) ? LAST_MASK : 8'hFF;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                preg_q[i] <= SLOT_RESET & MASK;
            end else if (wr_ok && cfg_addr == AW'(i + 1)) begin
                preg_q[i] <= cfg_wdata & MASK;
            end
        end
    end

    // Grouped byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_q <= GROUP_RESET;
        end else if (wr_ok && cfg_addr == AW'(ADDR_GRP)) begin
            grp_q <= cfg_wdata & GROUP_MASK;
        end
    end

    always_comb begin
        cfg_rdata = '0;
        if (cfg_addr == AW'(0)) cfg_rdata = priv_q;
        if (cfg_addr == AW'(ADDR_GRP)) cfg_rdata = grp_q;
        for (int i = 0; i < NUM_PREGS; i++) begin
            if (cfg_addr == AW'(i + 1)) cfg_rdata = preg_q[i];
        end
    end

    assign attr_en_q = priv_q[NUM_MASTERS+3:5];

    // R3: untrusted writes leave every register untouched
    p_untrusted_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !priv_q[cfg_master]) |=>
            ($stable(priv_q) && $stable(preg_q) && $stable(grp_q)));

    // R3: trusted write to the privilege byte lands on the next edge
    p_trusted_priv_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && priv_q[cfg_master] && cfg_addr == AW'(0)) |=>
            (priv_q == ($past(cfg_wdata) & PRIV_MASK)));

endmodule

// File: rtl/guard_priv.sv
module guard_priv #(
    parameter int NUM_MASTERS = 4,
    localparam int MW         = $clog2(NUM_MASTERS)
) (
    input  logic [NUM_MASTERS-1:1] attr_en,
    input  logic [MW-1:0]          acc_master,
    input  logic                   acc_super,
    output logic                   eff_super
);

    logic [NUM_MASTERS-1:0] honour;

    assign honour[0] = 1'b1;
    for (genvar n = 1; n < NUM_MASTERS; n++) begin : g_hon
        assign honour[n] = attr_en[n];
    end

    assign eff_super = acc_super && honour[acc_master];

endmodule

// File: rtl/guard_check.sv
module guard_check
    import guard_pkg::*;
#(
    parameter int NUM_PSLOTS  = 17,
    parameter int NUM_GSLOTS  = 14,
    parameter int SW          = 5,
    localparam int NUM_PREGS  = (NUM_PSLOTS + 1) / 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      eff_super,
    input  logic [1:0]                acc_kind,
    input  logic                      acc_grouped,
    input  logic [SW-1:0]             acc_slot,
    input  logic [NUM_PREGS-1:0][7:0] preg_q,
    input  logic [5:0]                grp_rights,
    output logic                      allow
);

    acc_kind_e  kind;
    logic [3:0] nib [NUM_PSLOTS];
    logic [3:0] nib_sel;
    logic       p_in_range;
    logic       g_in_range;
    logic       p_ok;
    logic       g_ok;

    assign kind = acc_kind_e'(acc_kind);

    for (genvar s = 0; s < NUM_PSLOTS; s++) begin : g_nib
        assign nib[s] = preg_q[s / 2][(s % 2) * 4 +: 4];
    end

    always_comb begin
        nib_sel = '0;
        for (int s = 0; s < NUM_PSLOTS; s++) begin
            if (acc_slot == SW'(s)) nib_sel = nib[s];
        end
    end

    assign p_in_range = (acc_slot < SW'(NUM_PSLOTS));
    assign g_in_range = (acc_slot < SW'(NUM_GSLOTS));

    always_comb begin
        p_ok = 1'b0;
        unique case (kind)
            KIND_READ:  p_ok = eff_super ? nib_sel[3] : nib_sel[1];
            KIND_WRITE: p_ok = eff_super ? nib_sel[2] : nib_sel[0];
            KIND_FETCH: p_ok = 1'b0;
            KIND_RSVD:  p_ok = 1'b0;
        endcase
    end

    always_comb begin
        g_ok = 1'b0;
        unique case (kind)
            KIND_READ:  g_ok = eff_super ? grp_rights[5] : grp_rights[2];
            KIND_WRITE: g_ok = eff_super ? grp_rights[4] : grp_rights[1];
            KIND_FETCH: g_ok = eff_super ? grp_rights[3] : grp_rights[0];
            KIND_RSVD:  g_ok = 1'b0;
        endcase
    end

    assign allow = acc_grouped ? (g_in_range && g_ok) : (p_in_range && p_ok);

    // R7: fetches into the per-slot space are never allowed
    p_no_pfetch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_grouped && kind == KIND_FETCH) |-> !allow);

    // R7 / R8: out-of-range slots are never allowed
    p_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((acc_grouped && !g_in_range) || (!acc_grouped && !p_in_range)) |-> !allow);

endmodule

// File: rtl/bus_access_guard.sv
module bus_access_guard #(
    parameter int NUM_MASTERS = 4,
    parameter int NUM_PSLOTS  = 17,
    parameter int NUM_GSLOTS  = 14,
    parameter int SW          = 5,
    parameter int AW          = 4,
    localparam int MW         = $clog2(NUM_MASTERS),
    localparam int NUM_PREGS  = (NUM_PSLOTS + 1) / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_valid,
    input  logic [MW-1:0] acc_master,
    input  logic          acc_super,
    input  logic [1:0]    acc_kind,
    input  logic          acc_grouped,
    input  logic [SW-1:0] acc_slot,
    output logic          acc_grant,
    output logic          acc_error,
    input  logic          cfg_we,
    input  logic [MW-1:0] cfg_master,
    input  logic [AW-1:0] cfg_addr,
    input  logic [7:0]    cfg_wdata,
    output logic [7:0]    cfg_rdata
);

    logic [NUM_MASTERS-1:1]    attr_en_q;
    logic [NUM_PREGS-1:0][7:0] preg_q;
    logic [7:0]                grp_q;
    logic                      eff_super;
    logic                      allow;

    guard_regs #(
        .NUM_MASTERS (NUM_MASTERS),
        .NUM_PSLOTS  (NUM_PSLOTS),
        .AW          (AW)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_master (cfg_master),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .attr_en_q  (attr_en_q),
        .preg_q     (preg_q),
        .grp_q      (grp_q)
    );

    guard_priv #(
        .NUM_MASTERS (NUM_MASTERS)
    ) u_priv (
        .attr_en    (attr_en_q),
        .acc_master (acc_master),
        .acc_super  (acc_super),
        .eff_super  (eff_super)
    );

    guard_check #(
        .NUM_PSLOTS (NUM_PSLOTS),
        .NUM_GSLOTS (NUM_GSLOTS),
        .SW         (SW)
    ) u_check (
        .clk         (clk),
        .rst_n       (rst_n),
        .eff_super   (eff_super),
        .acc_kind    (acc_kind),
        .acc_grouped (acc_grouped),
        .acc_slot    (acc_slot),
        .preg_q      (preg_q),
        .grp_rights  (grp_q[7:2]),
        .allow       (allow)
    );

    assign acc_grant = acc_valid && allow;
    assign acc_error = acc_valid && !allow;

    // R9: exactly one response per valid access
    p_one_response_r9: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> (acc_grant != acc_error));

    // R9: silence when idle
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> (!acc_grant && !acc_error));

    // R4: a non-core master without its enable never runs as supervisor
    p_user_forced_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_master != '0 && !attr_en_q[acc_master]) |-> !eff_super);

endmodule

// File: tb/bus_access_guard_bench.sv
`timescale 1ns/1ps
module bus_access_guard_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       acc_valid;
    logic [1:0] acc_master;
    logic       acc_super;
    logic [1:0] acc_kind;
    logic       acc_grouped;
    logic [4:0] acc_slot;
    logic       acc_grant;
    logic       acc_error;
    logic       cfg_we;
    logic [1:0] cfg_master;
    logic [3:0] cfg_addr;
    logic [7:0] cfg_wdata;
    logic [7:0] cfg_rdata;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [7:0] m_priv;
    logic [7:0] m_preg [9];
    logic [7:0] m_grp;

    always #2.5 clk = ~clk;

    bus_access_guard u_bus_access_guard (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_master(acc_master), .acc_super(acc_super),
        .acc_kind(acc_kind), .acc_grouped(acc_grouped), .acc_slot(acc_slot),
        .acc_grant(acc_grant), .acc_error(acc_error),
        .cfg_we(cfg_we), .cfg_master(cfg_master), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
    );

    function automatic logic [7:0] exp_rd(int a);
        if (a == 0) return m_priv;
        if (a >= 1 && a <= 9) return m_preg[a - 1];
        if (a == 10) return m_grp;
        return 8'h00;
    endfunction

    // Expected decision from R4, R6, R7, R8
    function automatic logic exp_allow(int m, int sup, int k, int g, int s);
        logic       eff;
        logic [7:0] nib;
        eff = (sup != 0) && (m == 0 || m_priv[4 + m]);
        if (k == 3) return 1'b0;
        if (g != 0) begin
            if (s >= 14) return 1'b0;
            if (eff) return m_grp[7 - k];
            return m_grp[4 - k];
        end
        if (s >= 17 || k == 2) return 1'b0;
        nib = m_preg[s / 2] >> ((s % 2) * 4);
        if (eff) return (k == 0) ? nib[3] : nib[2];
        return (k == 0) ? nib[1] : nib[0];
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(int m, int a, logic [7:0] d);
        logic trusted;
        trusted = m_priv[m];
        @(negedge clk);
        cfg_we = 1'b1; cfg_master = 2'(m); cfg_addr = 4'(a); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (trusted) begin
            if (a == 0) m_priv = d & 8'hEF;
            else if (a >= 1 && a <= 8) m_preg[a - 1] = d;
            else if (a == 9) m_preg[8] = d & 8'h0F;
            else if (a == 10) m_grp = d & 8'hFC;
        end
    endtask

    task automatic check_all_regs(string req);
        for (int a = 0; a < 16; a++) begin
            @(negedge clk);
            cfg_addr = 4'(a);
            #1;
            check(req, cfg_rdata, exp_rd(a), $sformatf("readback addr %0d", a));
        end
    endtask

    task automatic sweep(string req);
        for (int m = 0; m < 4; m++)
          for (int sp = 0; sp < 2; sp++)
            for (int k = 0; k < 4; k++)
              for (int g = 0; g < 2; g++)
                for (int s = 0; s < 32; s++) begin
                    logic e;
                    @(negedge clk);
                    acc_valid = 1'b1; acc_master = 2'(m); acc_super = sp[0];
                    acc_kind = 2'(k); acc_grouped = g[0]; acc_slot = 5'(s);
                    #1;
                    e = exp_allow(m, sp, k, g, s);
                    check(req, {6'd0, acc_grant, acc_error}, {6'd0, e, !e},
                          $sformatf("m%0d sup%0d kind%0d grp%0d slot%0d (R6 R7 R8 R9)",
                                    m, sp, k, g, s));
                end
        @(negedge clk);
        acc_valid = 1'b0;
        #1;
        check("R9", {6'd0, acc_grant, acc_error}, 8'd0, "idle outputs");
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; acc_valid = 1'b0; acc_master = '0; acc_super = 1'b0;
        acc_kind = '0; acc_grouped = 1'b0; acc_slot = '0;
        cfg_we = 1'b0; cfg_master = '0; cfg_addr = '0; cfg_wdata = '0;
        m_priv = 8'h01; m_grp = 8'hC0;
        for (int i = 0; i < 8; i++) m_preg[i] = 8'hCC;
        m_preg[8] = 8'h0C;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1, R2: reset readback and unmapped addresses
        check_all_regs("R1");
        // R4: at reset only master 0 may act as supervisor
        sweep("R4");

        // R3: untrusted writes ignored
        cfg_write(1, 1, 8'hFF);
        cfg_write(2, 0, 8'hFF);
        cfg_write(3, 10, 8'hFF);
        check_all_regs("R3");

        // R2, R5, R8: pad bits and unmapped address
        cfg_write(0, 9, 8'hFF);
        cfg_write(0, 10, 8'hFF);
        cfg_write(0, 12, 8'hFF);
        cfg_write(0, 0, 8'hFF);
        check_all_regs("R5");

        // Config A: master 0 trusts master 1, enables masters 1..3
        cfg_write(0, 0, 8'hE3);
        for (int i = 0; i < 9; i++) cfg_write(1, i + 1, 8'(i * 8'h4B + 8'h17));
        cfg_write(1, 10, 8'hA4);
        check_all_regs("R2");
        sweep("R6");

        // Config B: only master 1 may be supervisor; complemented rights
        cfg_write(0, 0, 8'h23);
        for (int i = 0; i < 9; i++) cfg_write(0, i + 1, ~8'(i * 8'h4B + 8'h17));
        cfg_write(0, 10, 8'h5C);
        sweep("R4");

        // Config C: master 0 hands trust to master 1 alone, then loses write access
        cfg_write(0, 0, 8'h42);
        cfg_write(0, 3, 8'h00);
        cfg_write(1, 3, 8'h96);
        cfg_write(1, 9, 8'h0A);
        cfg_write(1, 10, 8'h28);
        check_all_regs("R3");
        sweep("R7");

        // R5: slot 16 decodes from bits 3:0 of register 8
        cfg_write(1, 9, 8'h08);
        @(negedge clk);
        acc_valid = 1'b1; acc_master = 2'd0; acc_super = 1'b1;
        acc_kind = 2'd0; acc_grouped = 1'b0; acc_slot = 5'd16;
        #1;
        check("R5", {7'd0, acc_grant}, 8'd1, "slot 16 supervisor read");
        @(negedge clk);
        acc_valid = 1'b0;

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule